// File: doc/BRIEF.md
# Dual-Channel Machine-Cycle Timer/Counter

This block holds two timer/counter channels. Each channel has an 8-bit low count byte and an 8-bit high count byte. Software reads and writes these bytes through a small byte-wide register port. A channel counts either machine-cycle ticks or falling edges on an external count pin. A machine-cycle tick is one clock in every twelve, and the divide ratio is a parameter.

The control pins pick, for each channel, how the two bytes are chained. There are four chaining modes:
- a 13-bit counter with a 5-bit prescale;
- a plain 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- a split mode that turns channel 0 into two independent 8-bit counters.

When a channel rolls over, it raises a flag. The flag doubles as the interrupt request. A one-cycle acknowledge pulse clears the flag when the interrupt is taken.

A gate input lets an interrupt pin act as a hardware enable. The channel then measures how long that pin stays high. Control and status pins are plain levels. The register port has no handshake: a write lands on the next clock edge, and the read data reflects the current byte.

Top module: `dual_timer_counter`

## Requirements
- R1: After reset, all four count bytes read 0x00 and both flags are low.
- R2: Register port address map: 0 = channel-0 low byte, 1 = channel-0 high byte, 2 = channel-1 low byte, 3 = channel-1 high byte. A write updates the byte on the next clock edge. `reg_rdata` shows the addressed byte without delay.
- R3: With the channel's count-select low, a running channel advances by exactly one for every 12 clock cycles.
- R4: With count-select high, a running channel advances once for each 1-to-0 transition of its count pin. The pin is synchronised and sampled once per machine cycle, so each level must be held for at least 24 clocks.
- R5: With gate low, a channel runs whenever its run bit is high. With gate high, it also needs its interrupt pin to be high.
- R6: Mode 0 (code 2'b00) counts 13 bits. Bits [4:0] of the low byte form the prescale and carry into the high byte. Low-byte bits [7:5] keep their value. The flag rises when the high byte wraps.
- R7: Mode 1 (code 2'b01) counts 16 bits, with the high byte above the low byte. The flag rises on the wrap from 0xFFFF to 0x0000.
- R8: Mode 2 (code 2'b10) counts the low byte as 8 bits. Each wrap loads the low byte from the high byte and raises the flag.
- R9: Mode 3 (code 2'b11) on channel 0 counts the low byte as 8 bits, using channel 0's own run, gate and count-select controls. Its wrap raises flag 0.
- R10: While channel 0 is in mode 3, its high byte counts machine-cycle ticks whenever channel 1's run bit is high. Its wrap raises flag 1. Channel 1 keeps counting in its own mode, but channel 1's wraps no longer raise flag 1.
- R11: Channel 1 in mode 3 holds both of its bytes.
- R12: A flag stays high after an overflow until its acknowledge pulse clears it. An overflow in the same cycle as the acknowledge wins.
- R13: A register write in a cycle where that byte would also advance stores the written value, and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the count bytes |
| reg_addr | input | 2 | Byte select (see R2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Addressed byte |
| t0_mode | input | 2 | Channel 0 chaining mode |
| t0_gate | input | 1 | Channel 0 gate enable |
| t0_cnt_sel | input | 1 | Channel 0 source: 0 = ticks, 1 = pin edges |
| t0_run | input | 1 | Channel 0 run bit |
| t1_mode | input | 2 | Channel 1 chaining mode |
| t1_gate | input | 1 | Channel 1 gate enable |
| t1_cnt_sel | input | 1 | Channel 1 source select |
| t1_run | input | 1 | Channel 1 run bit (also drives the split high byte) |
| t0_pin | input | 1 | Channel 0 external count pin |
| t1_pin | input | 1 | Channel 1 external count pin |
| int0_pin | input | 1 | Channel 0 gate pin |
| int1_pin | input | 1 | Channel 1 gate pin |
| ack0 | input | 1 | Clears flag 0 (interrupt taken) |
| ack1 | input | 1 | Clears flag 1 |
| tf0 | output | 1 | Channel 0 overflow flag / interrupt request |
| tf1 | output | 1 | Channel 1 overflow flag / interrupt request |

## Verification
The bench goes after several rollover points:
- The 13-bit wrap from a low byte of 0xFF. A design that let the prescale carry into bits [7:5] would read 0x00 instead of 0xE0.
- The reload wrap. A design that wrapped to zero would read 0x01 in place of the reloaded value plus one.
- The 16-bit wrap, which checks that the flag rises when the count wraps and not before.

In split mode the bench checks three things:
- the high byte counts on channel 1's run bit alone;
- channel 1's own wrap is blocked from flag 1 (a design that kept it connected would raise a false interrupt);
- channel 1 freezes when it is itself put in mode 3.

Further corner cases:
- A write held across a tick must win over the increment. A design that let the increment win would read one more than the value written.
- Gated runs must stay still while the gate pin is low.
- Pin counting must count falling edges only, one per pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13     = 2'b00,
    MODE_16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] ADDR_LO0 = 2'd0;
  localparam logic [1:0] ADDR_HI0 = 2'd1;
  localparam logic [1:0] ADDR_LO1 = 2'd2;
  localparam logic [1:0] ADDR_HI1 = 2'd3;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
  parameter int CLK_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  assign tick = (cnt == LAST);

  // R3: ticks are spaced by the divide ratio, never back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (CLK_DIV > 1)) |=> !tick);
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/tmr_fall.sv
module tmr_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic lvl,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else if (tick) prev <= lvl;
  end

  assign fall = tick && prev && !lvl;

  // R4: an edge event is only reported on a machine-cycle tick
  a_r4_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> tick);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W        = 8,
  parameter int PRE_W    = 5,
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_mode_e     mode,
  input  logic          cnt_en,
  input  logic          hi_en,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  tl,
  output logic [W-1:0]  th,
  output logic          ovf_lo,
  output logic          ovf_hi
);
  localparam logic [W-1:0]     ONE_W  = W'(1);
  localparam logic [PRE_W-1:0] ONE_P  = PRE_W'(1);
  localparam logic [2*W-1:0]   ONE_2W = (2*W)'(1);

  logic [W-1:0] tl_n, th_n;

  always_comb begin
    tl_n   = tl;
    th_n   = th;
    ovf_lo = 1'b0;
    ovf_hi = 1'b0;
    case (mode)
      MODE_13: begin
        if (cnt_en) begin
          if (&tl[PRE_W-1:0]) begin
            tl_n[PRE_W-1:0] = '0;
            th_n   = th + ONE_W;
            ovf_lo = &th;
          end else begin
            tl_n[PRE_W-1:0] = tl[PRE_W-1:0] + ONE_P;
          end
        end
      end
      MODE_16: begin
        if (cnt_en) begin
          {th_n, tl_n} = {th, tl} + ONE_2W;
          ovf_lo = &{th, tl};
        end
      end
      MODE_RELOAD: begin
        if (cnt_en) begin
          if (&tl) begin
            tl_n   = th;
            ovf_lo = 1'b1;
          end else begin
            tl_n = tl + ONE_W;
          end
        end
      end
      default: begin
        if (SPLIT_OK) begin
          if (cnt_en) begin
            tl_n   = tl + ONE_W;
            ovf_lo = &tl;
          end
          if (hi_en) begin
            th_n   = th + ONE_W;
            ovf_hi = &th;
          end
        end
      end
    endcase
    if (wr_lo) tl_n = wdata;
    if (wr_hi) th_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tl <= '0;
      th <= '0;
    end else begin
      tl <= tl_n;
      th <= th_n;
    end
  end

  // R2 / R13: a low-byte write always lands, whatever the counter did
  a_r13_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> tl == $past(wdata));

  // R8: a reload wrap copies the high byte into the low byte
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RELOAD && cnt_en && (&tl) && !wr_lo && !wr_hi) |=> tl == $past(th));

  // R6: upper low-byte bits are untouched in 13-bit mode
  a_r6_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_13 && !wr_lo) |=> tl[W-1:PRE_W] == $past(tl[W-1:PRE_W]));

  // R11: a channel without split support freezes in mode 3
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!SPLIT_OK && mode == MODE_SPLIT && !wr_lo && !wr_hi) |=> ($stable(tl) && $stable(th)));
endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
  import tmr_pkg::*;
#(
  parameter int CLK_DIV   = 12,
  parameter int W         = 8,
  parameter int PRE_W     = 5,
  parameter int SYNC_STG  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [1:0]   t0_mode,
  input  logic         t0_gate,
  input  logic         t0_cnt_sel,
  input  logic         t0_run,
  input  logic [1:0]   t1_mode,
  input  logic         t1_gate,
  input  logic         t1_cnt_sel,
  input  logic         t1_run,
  input  logic         t0_pin,
  input  logic         t1_pin,
  input  logic         int0_pin,
  input  logic         int1_pin,
  input  logic         ack0,
  input  logic         ack1,
  output logic         tf0,
  output logic         tf1
);
  localparam int NPIN = 4;

  logic tick;
  logic [NPIN-1:0] pin_raw, pin_s;
  logic [1:0] fall;

  tmr_tick #(.CLK_DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  // pins: 0 = t0 count, 1 = t1 count, 2 = int0 gate, 3 = int1 gate
  assign pin_raw = {int1_pin, int0_pin, t1_pin, t0_pin};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    tmr_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw[g]), .q(pin_s[g]));
  end

  for (genvar g = 0; g < 2; g++) begin : g_fall
    tmr_fall u_fall (
      .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(pin_s[g]), .fall(fall[g]));
  end

  tmr_mode_e m0, m1;
  assign m0 = tmr_mode_e'(t0_mode);
  assign m1 = tmr_mode_e'(t1_mode);

  logic go0, go1, ev0, ev1, hi0;
  assign go0 = t0_run && (!t0_gate || pin_s[2]);
  assign go1 = t1_run && (!t1_gate || pin_s[3]);
  assign ev0 = go0 && (t0_cnt_sel ? fall[0] : tick);
  assign ev1 = go1 && (t1_cnt_sel ? fall[1] : tick);
  assign hi0 = tick && t1_run;

  logic wl0, wh0, wl1, wh1;
  assign wl0 = reg_wr && (reg_addr == ADDR_LO0);
  assign wh0 = reg_wr && (reg_addr == ADDR_HI0);
  assign wl1 = reg_wr && (reg_addr == ADDR_LO1);
  assign wh1 = reg_wr && (reg_addr == ADDR_HI1);

  logic [W-1:0] tl0, th0, tl1, th1;
  logic ovf0_lo, ovf0_hi, ovf1_lo, ovf1_hi;

  tmr_chan #(.W(W), .PRE_W(PRE_W), .SPLIT_OK(1'b1)) u_ch0 (
    .clk(clk), .rst_n(rst_n), .mode(m0), .cnt_en(ev0), .hi_en(hi0),
    .wr_lo(wl0), .wr_hi(wh0), .wdata(reg_wdata),
    .tl(tl0), .th(th0), .ovf_lo(ovf0_lo), .ovf_hi(ovf0_hi));

  tmr_chan #(.W(W), .PRE_W(PRE_W), .SPLIT_OK(1'b0)) u_ch1 (
    .clk(clk), .rst_n(rst_n), .mode(m1), .cnt_en(ev1), .hi_en(1'b0),
    .wr_lo(wl1), .wr_hi(wh1), .wdata(reg_wdata),
    .tl(tl1), .th(th1), .ovf_lo(ovf1_lo), .ovf_hi(ovf1_hi));

  logic set0, set1;
  assign set0 = ovf0_lo;
  assign set1 = ((m0 == MODE_SPLIT) ? ovf0_hi : ovf1_lo) | ovf1_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tf0 <= 1'b0;
      tf1 <= 1'b0;
    end else begin
      tf0 <= set0 | (tf0 & ~ack0);
      tf1 <= set1 | (tf1 & ~ack1);
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_LO0: reg_rdata = tl0;
      ADDR_HI0: reg_rdata = th0;
      ADDR_LO1: reg_rdata = tl1;
      default:  reg_rdata = th1;
    endcase
  end

  // R12: an overflow always leaves its flag high
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovf0_lo |=> tf0);

  // R12: acknowledge without a new overflow drops the flag
  a_r12_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tf0 && ack0 && !ovf0_lo) |=> !tf0);

  // R10: in split mode channel 1's own wrap cannot raise flag 1
  a_r10_borrowed_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (m0 == MODE_SPLIT && ovf1_lo && !ovf0_hi && !tf1) |=> !tf1);
endmodule

// File: tb/tb_dual_timer_counter.sv
`timescale 1ns/1ps
module tb_dual_timer_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] t0_mode = 2'd1, t1_mode = 2'd1;
  logic t0_gate = 0, t0_cnt_sel = 0, t0_run = 0;
  logic t1_gate = 0, t1_cnt_sel = 0, t1_run = 0;
  logic t0_pin = 1, t1_pin = 1, int0_pin = 1, int1_pin = 1;
  logic ack0 = 0, ack1 = 0;
  logic tf0, tf1;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_timer_counter dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .t0_mode(t0_mode), .t0_gate(t0_gate), .t0_cnt_sel(t0_cnt_sel), .t0_run(t0_run),
    .t1_mode(t1_mode), .t1_gate(t1_gate), .t1_cnt_sel(t1_cnt_sel), .t1_run(t1_run),
    .t0_pin(t0_pin), .t1_pin(t1_pin), .int0_pin(int0_pin), .int1_pin(int1_pin),
    .ack0(ack0), .ack1(ack1), .tf0(tf0), .tf1(tf1));

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] tl;
    logic [7:0] th;
    logic [7:0] n;
    logic [7:0] etl;
    logic [7:0] eth;
    logic       etf0;
  } vec_t;

  // mode, start low, start high, ticks, expected low, expected high, flag 0
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h10, 8'h00, 8'd5, 8'h15, 8'h00, 1'b0},  // R7 plain count
    '{2'd1, 8'hFE, 8'h00, 8'd3, 8'h01, 8'h01, 1'b0},  // R7 carry to high
    '{2'd1, 8'hFF, 8'hFF, 8'd2, 8'h01, 8'h00, 1'b1},  // R7 16-bit wrap
    '{2'd0, 8'h1E, 8'h00, 8'd3, 8'h01, 8'h01, 1'b0},  // R6 prescale carry
    '{2'd0, 8'hFF, 8'hFF, 8'd1, 8'hE0, 8'h00, 1'b1},  // R6 wrap, upper bits kept
    '{2'd2, 8'hFE, 8'h80, 8'd3, 8'h81, 8'h80, 1'b1},  // R8 reload
    '{2'd2, 8'h10, 8'h55, 8'd4, 8'h14, 8'h55, 1'b0},  // R8 no wrap
    '{2'd3, 8'hFF, 8'h00, 8'd2, 8'h01, 8'h00, 1'b1}   // R9 split low byte
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run0(input int n);
    @(negedge clk); t0_run = 1'b1;
    repeat (12*n) @(negedge clk);
    t0_run = 1'b0;
  endtask

  task automatic run1(input int n);
    @(negedge clk); t1_run = 1'b1;
    repeat (12*n) @(negedge clk);
    t1_run = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk); ack0 = 1'b1; ack1 = 1'b1;
    @(negedge clk); ack0 = 1'b0; ack1 = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset byte", v, 8'h00);
    end
    chk("R1 reset tf0", {7'd0, tf0}, 8'h00);
    chk("R1 reset tf1", {7'd0, tf1}, 8'h00);

    // vector table: channel 0, tick source, R3/R2
    for (int i = 0; i < NV; i++) begin
      t0_mode = VECS[i].mode;
      clr_flags();
      wr(2'd0, VECS[i].tl);
      wr(2'd1, VECS[i].th);
      run0(int'(VECS[i].n));
      rd(2'd0, v); chk("R2/R3 vector low", v, VECS[i].etl);
      rd(2'd1, v); chk("R2/R3 vector high", v, VECS[i].eth);
      chk("R12 vector tf0", {7'd0, tf0}, {7'd0, VECS[i].etf0});
      chk("R10 vector tf1 quiet", {7'd0, tf1}, 8'h00);
      if (i == 2) begin
        clr_flags();
        chk("R12 ack clears tf0", {7'd0, tf0}, 8'h00);
      end
    end

    // R13 write held across ticks wins over the increment
    t0_mode = 2'd1;
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 8'h40; reg_wr = 1'b1; t0_run = 1'b1;
    repeat (24) @(negedge clk);
    reg_wr = 1'b0; t0_run = 1'b0;
    rd(2'd0, v); chk("R13 write overrides", v, 8'h40);

    // R4 external pin edge counting
    t0_cnt_sel = 1'b1;
    wr(2'd0, 8'h20); wr(2'd1, 8'h00);
    @(negedge clk); t0_run = 1'b1;
    repeat (30) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      t0_pin = 1'b0; repeat (24) @(negedge clk);
      t0_pin = 1'b1; repeat (24) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    t0_run = 1'b0;
    t0_cnt_sel = 1'b0;
    rd(2'd0, v); chk("R4 pin edges", v, 8'h24);

    // R5 gate
    t0_gate = 1'b1; int0_pin = 1'b0;
    wr(2'd0, 8'h00);
    repeat (10) @(negedge clk);
    run0(6);
    rd(2'd0, v); chk("R5 gated off", v, 8'h00);
    int0_pin = 1'b1;
    repeat (10) @(negedge clk);
    run0(6);
    rd(2'd0, v); chk("R5 gated on", v, 8'h06);
    t0_gate = 1'b0;

    // channel 1 plain 16-bit overflow
    t1_mode = 2'd1; clr_flags();
    wr(2'd2, 8'hFE); wr(2'd3, 8'hFF);
    run1(3);
    rd(2'd2, v); chk("R7 ch1 low", v, 8'h01);
    rd(2'd3, v); chk("R7 ch1 high", v, 8'h00);
    chk("R12 ch1 tf1", {7'd0, tf1}, 8'h01);

    // R10 split high byte on channel 1 run
    t0_mode = 2'd3; clr_flags();
    wr(2'd0, 8'h00); wr(2'd1, 8'hFE);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    run1(3);
    rd(2'd1, v); chk("R10 split high", v, 8'h01);
    rd(2'd0, v); chk("R10 split low idle", v, 8'h00);
    rd(2'd2, v); chk("R10 ch1 keeps counting", v, 8'h03);
    chk("R10 tf1 from split", {7'd0, tf1}, 8'h01);
    chk("R10 tf0 quiet", {7'd0, tf0}, 8'h00);
    clr_flags();
    wr(2'd1, 8'h00); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    run1(2);
    rd(2'd2, v); chk("R10 ch1 wrapped", v, 8'h01);
    chk("R10 ch1 wrap blocked", {7'd0, tf1}, 8'h00);

    // R11 channel 1 in mode 3 holds
    t0_mode = 2'd1; t1_mode = 2'd3; clr_flags();
    wr(2'd2, 8'h33); wr(2'd3, 8'h44);
    run1(5);
    rd(2'd2, v); chk("R11 ch1 low held", v, 8'h33);
    rd(2'd3, v); chk("R11 ch1 high held", v, 8'h44);
    chk("R11 tf1 quiet", {7'd0, tf1}, 8'h00);

    finish_run();
  end
endmodule